// File: doc/BRIEF.md
# LAPD Frame Address Filter

This block sits behind an HDLC deframer on a D-channel receive path and decides, frame by frame, whether a frame is addressed to this terminal. It takes a byte stream that has already been de-stuffed and stripped of flags. Each byte carries a start-of-frame and an end-of-frame marker. The block compares the leading address bytes against two programmable SAPI values, two programmable TEI values and the fixed broadcast (group) values. Frames that match are passed on without their address bytes. Frames that do not match disappear without trace.

Two recognition depths are supported: a single address byte that carries only a TEI, and the normal two-byte LAPD address (SAPI octet followed by TEI octet). The depth is chosen by a 3-bit mode code. The command/response bit is left out of the comparison, but its value is reported. Each accepted frame ends with a one-cycle status word that says which entry matched on each address level.

The mode and the match registers are captured with the first byte of every frame. Software can therefore rewrite them at any time without disturbing a frame that is already arriving.

Top module: `lapd_addr_filter`

## Requirements
- R1: While and after reset, with no frame applied, `out_valid`, `out_last` and `stat_valid` are 0.
- R2: Mode code 3'b010 (one-byte address): the first byte carries the TEI in bits 7:1 and must have bit 0 = 1. The TEI is compared with `tei1_i`, `tei2_i` and the group TEI 7'h7F. On acceptance, status bits 4:2 are 0.
- R3: Mode code 3'b011 (two-byte address): byte one carries the SAPI in bits 7:2 and must have bit 0 = 0. The SAPI is compared with `sap1_i`, `sap2_i` and the group SAPI 6'h3F (bytes 0xFC/0xFE). Byte two carries the TEI in bits 7:1 and must have bit 0 = 1. The TEI is compared as in R2. Both levels must match.
- R4: In two-byte mode, bit 1 of byte one (C/R) has no effect on matching. Its received value appears in status bit 4.
- R5: The hit code for each level is 1 for the first register, 2 for the second register and 3 for the group value. When several entries match, the first register wins over the second, and the second wins over the group.
- R6: For an accepted frame, every byte after the address field appears on `out_data` with `out_valid` one cycle after it is presented. `out_last` is high with the byte that carried end-of-frame.
- R7: A frame whose address does not match, or whose extension bits are wrong, produces no `out_valid` and no `stat_valid`.
- R8: A frame that ends before its full address has arrived is discarded with no output and no status.
- R9: For an accepted frame, `stat_valid` is high for one cycle, one cycle after the end-of-frame byte. `stat_code` holds {C/R, SAPI hit[1:0], TEI hit[1:0]}. This also applies when the frame has no bytes after the address.
- R10: Any mode code other than 3'b010 and 3'b011 discards every frame.
- R11: The mode and the four match registers are taken from the start-of-frame byte's cycle. Changing them later in the frame does not change that frame's outcome.
- R12: Bytes presented outside a frame (no start-of-frame since the last end-of-frame) are ignored. A start-of-frame byte inside a frame abandons the old frame and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Recognition mode code |
| sap1_i | input | 6 | First programmable SAPI |
| sap2_i | input | 6 | Second programmable SAPI |
| tei1_i | input | 7 | First programmable TEI |
| tei2_i | input | 7 | Second programmable TEI |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| out_valid | output | 1 | Forwarded byte valid |
| out_data | output | 8 | Forwarded byte |
| out_last | output | 1 | Forwarded byte is the frame's last |
| stat_valid | output | 1 | Status word valid (accepted frame ended) |
| stat_code | output | 5 | {C/R, SAPI hit, TEI hit} |

## Verification
A vector table drives frames that each hit a different register (first, second, group), with both values of the C/R bit and with payload lengths from zero to several bytes. This separates the hit encodings and the address stripping. Near-miss addresses, each differing only in the SAPI, the TEI or one extension bit, show that every field and both extension rules are enforced independently. Unused mode codes, truncated addresses, stray bytes between frames, a start-of-frame that interrupts a frame, overlapping register values and a mid-frame register rewrite cover the priority order, the abort path and the sampling point.

// File: rtl/lapd_af_pkg.sv
package lapd_af_pkg;
  localparam int BYTE_W = 8;
  localparam int SAPI_W = 6;
  localparam int TEI_W  = 7;
  localparam int MODE_W = 3;
  localparam int HIT_W  = 2;
  localparam int STAT_W = 1 + 2 * HIT_W;

  localparam logic [MODE_W-1:0] MODE_ONE_BYTE = 3'b010;
  localparam logic [MODE_W-1:0] MODE_TWO_BYTE = 3'b011;
  localparam logic [SAPI_W-1:0] SAPI_GROUP    = '1;
  localparam logic [TEI_W-1:0]  TEI_GROUP     = '1;

  typedef enum logic [1:0] {MK_OFF, MK_ONE, MK_TWO} mkind_t;

  typedef enum logic [HIT_W-1:0] {
    HIT_NONE  = 2'd0,
    HIT_REG1  = 2'd1,
    HIT_REG2  = 2'd2,
    HIT_GROUP = 2'd3
  } hit_t;

  function automatic mkind_t decode_mode(input logic [MODE_W-1:0] m);
    if (m == MODE_ONE_BYTE)      return MK_ONE;
    else if (m == MODE_TWO_BYTE) return MK_TWO;
    else                         return MK_OFF;
  endfunction

  // priority: register 1, then register 2, then group (R5)
  function automatic hit_t sapi_hit(input logic [SAPI_W-1:0] f,
                                    input logic [SAPI_W-1:0] r1,
                                    input logic [SAPI_W-1:0] r2);
    if (f == r1)              return HIT_REG1;
    else if (f == r2)         return HIT_REG2;
    else if (f == SAPI_GROUP) return HIT_GROUP;
    else                      return HIT_NONE;
  endfunction

  function automatic hit_t tei_hit(input logic [TEI_W-1:0] f,
                                   input logic [TEI_W-1:0] r1,
                                   input logic [TEI_W-1:0] r2);
    if (f == r1)             return HIT_REG1;
    else if (f == r2)        return HIT_REG2;
    else if (f == TEI_GROUP) return HIT_GROUP;
    else                     return HIT_NONE;
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(input logic cr,
                                                     input hit_t s,
                                                     input hit_t t);
    return {cr, s, t};
  endfunction
endpackage

// File: rtl/lapd_af_cfg.sv
// Captures mode and match registers with the start-of-frame byte (R11).
module lapd_af_cfg
  import lapd_af_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [SAPI_W-1:0] sap1_i,
  input  logic [SAPI_W-1:0] sap2_i,
  input  logic [TEI_W-1:0]  tei1_i,
  input  logic [TEI_W-1:0]  tei2_i,
  output mkind_t            kind_o,
  output logic [SAPI_W-1:0] sap1_o,
  output logic [SAPI_W-1:0] sap2_o,
  output logic [TEI_W-1:0]  tei1_o,
  output logic [TEI_W-1:0]  tei2_o
);
  mkind_t            kind_q;
  logic [SAPI_W-1:0] sap1_q, sap2_q;
  logic [TEI_W-1:0]  tei1_q, tei2_q;
  logic              take_live;

  assign take_live = in_valid && in_sof;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= MK_OFF;
      sap1_q <= '0;
      sap2_q <= '0;
      tei1_q <= '0;
      tei2_q <= '0;
    end else if (take_live) begin
      kind_q <= decode_mode(mode_i);
      sap1_q <= sap1_i;
      sap2_q <= sap2_i;
      tei1_q <= tei1_i;
      tei2_q <= tei2_i;
    end
  end

  // first byte sees the live registers, the rest of the frame the captured copy
  assign kind_o = take_live ? decode_mode(mode_i) : kind_q;
  assign sap1_o = take_live ? sap1_i : sap1_q;
  assign sap2_o = take_live ? sap2_i : sap2_q;
  assign tei1_o = take_live ? tei1_i : tei1_q;
  assign tei2_o = take_live ? tei2_i : tei2_q;
endmodule

// File: rtl/lapd_af_match.sv
// Compares the address fields of the current byte against the effective registers.
module lapd_af_match
  import lapd_af_pkg::*;
(
  input  logic [SAPI_W-1:0] sapi_fld,
  input  logic [TEI_W-1:0]  tei_fld,
  input  logic [SAPI_W-1:0] sap1,
  input  logic [SAPI_W-1:0] sap2,
  input  logic [TEI_W-1:0]  tei1,
  input  logic [TEI_W-1:0]  tei2,
  output hit_t              sapi_h,
  output hit_t              tei_h
);
  assign sapi_h = sapi_hit(sapi_fld, sap1, sap2);
  assign tei_h  = tei_hit(tei_fld, tei1, tei2);
endmodule

// File: rtl/lapd_af_ctrl.sv
// Frame state machine: address acceptance, payload forwarding, status.
module lapd_af_ctrl
  import lapd_af_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  mkind_t            cfg_kind,
  input  hit_t              sapi_h,
  input  hit_t              tei_h,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last,
  output logic              stat_valid,
  output logic [STAT_W-1:0] stat_code
);
  typedef enum logic [1:0] {S_IDLE, S_ADDR2, S_PASS, S_DROP} st_t;

  st_t  st_q, st_d;
  hit_t sapi_q, sapi_d, tei_q, tei_d;
  logic cr_q, cr_d;

  // named internal events
  logic addr_accept;   // full address matched on this byte
  logic addr_reject;   // address failed or frame cut short
  logic fwd_byte;      // byte belongs to accepted payload
  logic frame_ok_end;  // accepted frame ends on this byte

  logic ea_bit, cr_bit;
  assign ea_bit = in_data[0];
  assign cr_bit = in_data[1];

  always_comb begin
    st_d         = st_q;
    sapi_d       = sapi_q;
    tei_d        = tei_q;
    cr_d         = cr_q;
    addr_accept  = 1'b0;
    addr_reject  = 1'b0;
    fwd_byte     = 1'b0;
    frame_ok_end = 1'b0;
    if (in_valid) begin
      if (in_sof) begin
        // R12: a start marker always opens a fresh frame
        unique case (cfg_kind)
          MK_ONE: begin
            if (ea_bit && tei_h != HIT_NONE) begin
              addr_accept  = 1'b1;
              sapi_d       = HIT_NONE;
              tei_d        = tei_h;
              cr_d         = 1'b0;
              frame_ok_end = in_eof;
              st_d         = in_eof ? S_IDLE : S_PASS;
            end else begin
              addr_reject = 1'b1;
              st_d        = in_eof ? S_IDLE : S_DROP;
            end
          end
          MK_TWO: begin
            if (!ea_bit && sapi_h != HIT_NONE && !in_eof) begin
              sapi_d = sapi_h;
              cr_d   = cr_bit;
              st_d   = S_ADDR2;
            end else begin
              addr_reject = 1'b1;  // includes R8 truncation
              st_d        = in_eof ? S_IDLE : S_DROP;
            end
          end
          default: begin
            addr_reject = 1'b1;    // R10
            st_d        = in_eof ? S_IDLE : S_DROP;
          end
        endcase
      end else begin
        unique case (st_q)
          S_ADDR2: begin
            if (ea_bit && tei_h != HIT_NONE) begin
              addr_accept  = 1'b1;
              tei_d        = tei_h;
              frame_ok_end = in_eof;
              st_d         = in_eof ? S_IDLE : S_PASS;
            end else begin
              addr_reject = 1'b1;
              st_d        = in_eof ? S_IDLE : S_DROP;
            end
          end
          S_PASS: begin
            fwd_byte     = 1'b1;
            frame_ok_end = in_eof;
            if (in_eof) st_d = S_IDLE;
          end
          S_DROP: begin
            if (in_eof) st_d = S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      sapi_q     <= HIT_NONE;
      tei_q      <= HIT_NONE;
      cr_q       <= 1'b0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_last   <= 1'b0;
      stat_valid <= 1'b0;
      stat_code  <= '0;
    end else begin
      st_q       <= st_d;
      sapi_q     <= sapi_d;
      tei_q      <= tei_d;
      cr_q       <= cr_d;
      out_valid  <= fwd_byte;
      out_data   <= in_data;
      out_last   <= fwd_byte && in_eof;
      stat_valid <= frame_ok_end;
      if (frame_ok_end) stat_code <= pack_status(cr_d, sapi_d, tei_d);
    end
  end

  // R9: status only follows an end-of-frame byte
  a_r9_status_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> $past(in_valid && in_eof));

  // R9: an accepted frame always names the matching TEI entry
  a_r9_status_has_tei: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> stat_code[HIT_W-1:0] != HIT_NONE);

  // R6: last marker only with a forwarded byte
  a_r6_last_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R8: one-byte frame in two-byte mode never yields status
  a_r8_short_no_status: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && in_eof && cfg_kind == MK_TWO) |=> !stat_valid);

  // R7: rejection and acceptance never coincide
  a_r7_accept_xor_reject: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_accept && addr_reject));

  // R12: end of frame returns to waiting for a start marker
  a_r12_eof_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eof) |=> st_q == S_IDLE);
endmodule

// File: rtl/lapd_addr_filter.sv
module lapd_addr_filter
  import lapd_af_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [SAPI_W-1:0] sap1_i,
  input  logic [SAPI_W-1:0] sap2_i,
  input  logic [TEI_W-1:0]  tei1_i,
  input  logic [TEI_W-1:0]  tei2_i,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last,
  output logic              stat_valid,
  output logic [STAT_W-1:0] stat_code
);
  mkind_t            kind;
  logic [SAPI_W-1:0] sap1, sap2;
  logic [TEI_W-1:0]  tei1, tei2;
  hit_t              sapi_h, tei_h;

  lapd_af_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .mode_i(mode_i), .sap1_i(sap1_i), .sap2_i(sap2_i),
    .tei1_i(tei1_i), .tei2_i(tei2_i),
    .kind_o(kind), .sap1_o(sap1), .sap2_o(sap2), .tei1_o(tei1), .tei2_o(tei2)
  );

  lapd_af_match u_match (
    .sapi_fld(in_data[BYTE_W-1:BYTE_W-SAPI_W]),
    .tei_fld(in_data[BYTE_W-1:BYTE_W-TEI_W]),
    .sap1(sap1), .sap2(sap2), .tei1(tei1), .tei2(tei2),
    .sapi_h(sapi_h), .tei_h(tei_h)
  );

  lapd_af_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .cfg_kind(kind),
    .sapi_h(sapi_h), .tei_h(tei_h),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .stat_valid(stat_valid), .stat_code(stat_code)
  );
endmodule

// File: tb/lapd_addr_filter_test.sv
`timescale 1ns/1ps
module lapd_addr_filter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_i = 3'b011;
  logic [5:0] sap1_i = 6'h10, sap2_i = 6'h21;
  logic [6:0] tei1_i = 7'h05, tei2_i = 7'h40;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       out_valid, out_last, stat_valid;
  logic [7:0] out_data;
  logic [4:0] stat_code;

  int n_tests = 0, n_fail = 0;
  int n_out = 0, n_last = 0, n_stat = 0, n_bad_data = 0, pay_idx = 0;
  logic [4:0] last_stat = '0;
  bit done = 0;

  always #10 clk = ~clk;

  lapd_addr_filter uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sap1_i(sap1_i), .sap2_i(sap2_i),
    .tei1_i(tei1_i), .tei2_i(tei2_i), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .stat_valid(stat_valid), .stat_code(stat_code)
  );

  // output monitor: payload byte k is expected to be 8'hA0 + k
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (out_data !== 8'(8'hA0 + pay_idx)) n_bad_data++;
        pay_idx++;
        n_out++;
        if (out_last) begin n_last++; pay_idx = 0; end
      end
      if (stat_valid) begin n_stat++; last_stat = stat_code; end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] d, input logic s, input logic e);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
  endtask

  task automatic idle_in();
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic send_frame(input logic [2:0] m, input logic [7:0] b0,
                            input logic [7:0] b1, input int npay);
    int alen;
    alen = (m == 3'b010) ? 1 : 2;
    mode_i = m;
    for (int i = 0; i < alen + npay; i++) begin
      logic [7:0] d;
      if (i == 0) d = b0;
      else if (i == 1 && alen == 2) d = b1;
      else d = 8'(8'hA0 + i - alen);
      drive(d, i == 0, i == alen + npay - 1);
    end
    idle_in();
  endtask

  // compares outcome against counters sampled before the frame
  task automatic expect_frame(input string tag, input bit acc, input logic [4:0] st,
                              input int npay, input int o0, input int l0,
                              input int s0, input int b0);
    repeat (2) @(negedge clk);
    if (acc) begin
      chk(n_stat - s0 == 1, {tag, " status count"}, n_stat - s0, 1);
      chk(last_stat == st, {tag, " status code"}, last_stat, st);
      chk(n_out - o0 == npay, {tag, " payload count"}, n_out - o0, npay);
      chk(n_last - l0 == (npay > 0 ? 1 : 0), {tag, " last marker"}, n_last - l0, npay > 0);
      chk(n_bad_data == b0, {tag, " payload data"}, n_bad_data - b0, 0);
    end else begin
      chk(n_stat == s0, {tag, " no status"}, n_stat - s0, 0);
      chk(n_out == o0, {tag, " no payload"}, n_out - o0, 0);
    end
  endtask

  typedef struct packed {
    logic [3:0] rq;
    logic [2:0] mode;
    logic [7:0] b0;
    logic [7:0] b1;
    logic [3:0] npay;
    logic       acc;
    logic [4:0] st;
  } vec_t;

  // R2 one-byte, R3 two-byte, R4 C/R, R5 codes, R6 forwarding, R7 reject, R10 modes
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{4'd3,  3'b011, 8'h40, 8'h0B, 4'd3, 1'b1, 5'h05},
    '{4'd5,  3'b011, 8'h86, 8'h81, 4'd2, 1'b1, 5'h1A},
    '{4'd5,  3'b011, 8'hFC, 8'hFF, 4'd1, 1'b1, 5'h0F},
    '{4'd4,  3'b011, 8'hFE, 8'h0B, 4'd2, 1'b1, 5'h1D},
    '{4'd7,  3'b011, 8'h3C, 8'h0B, 4'd2, 1'b0, 5'h00},
    '{4'd7,  3'b011, 8'h40, 8'h0D, 4'd2, 1'b0, 5'h00},
    '{4'd7,  3'b011, 8'h41, 8'h0B, 4'd2, 1'b0, 5'h00},
    '{4'd7,  3'b011, 8'h40, 8'h0A, 4'd2, 1'b0, 5'h00},
    '{4'd2,  3'b010, 8'h0B, 8'h00, 4'd2, 1'b1, 5'h01},
    '{4'd2,  3'b010, 8'hFF, 8'h00, 4'd3, 1'b1, 5'h03},
    '{4'd2,  3'b010, 8'h0A, 8'h00, 4'd2, 1'b0, 5'h00},
    '{4'd2,  3'b010, 8'h81, 8'h00, 4'd1, 1'b1, 5'h02},
    '{4'd10, 3'b000, 8'h40, 8'h0B, 4'd2, 1'b0, 5'h00},
    '{4'd10, 3'b111, 8'h40, 8'h0B, 4'd2, 1'b0, 5'h00},
    '{4'd9,  3'b011, 8'h42, 8'h0B, 4'd0, 1'b1, 5'h15},
    '{4'd6,  3'b011, 8'h86, 8'h0B, 4'd4, 1'b1, 5'h19}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == 0 && stat_valid == 0 && out_last == 0, "R1 reset outputs",
        {out_valid, out_last, stat_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid == 0 && stat_valid == 0, "R1 idle after reset",
        {out_valid, stat_valid}, 0);

    for (int v = 0; v < NV; v++) begin
      int o0, l0, s0, b0;
      o0 = n_out; l0 = n_last; s0 = n_stat; b0 = n_bad_data;
      send_frame(VECS[v].mode, VECS[v].b0, VECS[v].b1, int'(VECS[v].npay));
      expect_frame($sformatf("R%0d vector %0d", VECS[v].rq, v), VECS[v].acc,
                   VECS[v].st, int'(VECS[v].npay), o0, l0, s0, b0);
    end

    begin : directed
      int o0, l0, s0, b0;
      // R8: two-byte mode, frame ends on the first address byte
      o0 = n_out; l0 = n_last; s0 = n_stat; b0 = n_bad_data;
      mode_i = 3'b011;
      drive(8'h40, 1'b1, 1'b1);
      idle_in();
      expect_frame("R8 truncated address", 1'b0, 5'h00, 0, o0, l0, s0, b0);

      // R12: stray bytes with no start marker
      o0 = n_out; l0 = n_last; s0 = n_stat; b0 = n_bad_data;
      drive(8'h40, 1'b0, 1'b0);
      drive(8'h0B, 1'b0, 1'b0);
      drive(8'hA0, 1'b0, 1'b1);
      idle_in();
      expect_frame("R12 bytes outside frame", 1'b0, 5'h00, 0, o0, l0, s0, b0);

      // R12: start marker abandons a dropped frame in progress
      o0 = n_out; l0 = n_last; s0 = n_stat; b0 = n_bad_data;
      drive(8'h3C, 1'b1, 1'b0);
      drive(8'hA0, 1'b0, 1'b0);
      send_frame(3'b011, 8'h40, 8'h0B, 2);
      expect_frame("R12 restart on new start", 1'b1, 5'h05, 2, o0, l0, s0, b0);

      // R11: registers and mode rewritten after the first byte
      o0 = n_out; l0 = n_last; s0 = n_stat; b0 = n_bad_data;
      mode_i = 3'b011;
      drive(8'h40, 1'b1, 1'b0);
      @(negedge clk);
      mode_i = 3'b000; sap1_i = 6'h11; tei1_i = 7'h06;
      in_data = 8'h0B; in_sof = 1'b0; in_eof = 1'b0;
      drive(8'hA0, 1'b0, 1'b1);
      idle_in();
      expect_frame("R11 mid-frame rewrite", 1'b1, 5'h05, 1, o0, l0, s0, b0);
      sap1_i = 6'h10; tei1_i = 7'h05;

      // R5: overlapping registers, first register wins
      o0 = n_out; l0 = n_last; s0 = n_stat; b0 = n_bad_data;
      sap2_i = 6'h10; tei2_i = 7'h05;
      send_frame(3'b011, 8'h40, 8'h0B, 1);
      expect_frame("R5 reg1 over reg2", 1'b1, 5'h05, 1, o0, l0, s0, b0);

      // R5: register equal to group value beats group
      o0 = n_out; l0 = n_last; s0 = n_stat; b0 = n_bad_data;
      tei1_i = 7'h7F;
      send_frame(3'b011, 8'hFC, 8'hFF, 1);
      expect_frame("R5 reg1 over group", 1'b1, 5'h0D, 1, o0, l0, s0, b0);

      // R9: one-byte frame with no payload in one-byte mode
      o0 = n_out; l0 = n_last; s0 = n_stat; b0 = n_bad_data;
      send_frame(3'b010, 8'hFF, 8'h00, 0);
      expect_frame("R9 status without payload", 1'b1, 5'h01, 0, o0, l0, s0, b0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule